// File: doc/BRIEF.md
# Shared-Memory Wait-State Generator

This block decides how long a single bus access of a coprocessor lasts when that coprocessor shares its memories with a main processor. For each request it receives two region codes: the region the coprocessor is touching and the region the main processor is touching in the same cycle. It also receives the kind of access and, for a taken branch, the lowest bit of the branch target. From these it computes a cost in clock cycles. It holds that cost on `stall_count` and pulses `ready` once the cost has elapsed.

The cost has two parts. The memory part depends on the region and on whether the two processors collide in it. The control-flow part is added when a jump or return ends, or a branch is taken, while code runs from program ROM. Region decoding happens upstream. The requester raises `req_valid` with the fields valid and keeps it high until it sees `ready`.

A running 64-bit total of all charged cycles is kept so that a bench can check the accumulated timing.

Top module: `ws_wait_state_gen`

## Requirements
- R1: A conflict exists only when both region codes are equal and the code is not the register space (region 4). Register-space reads by both sides therefore cost 1 cycle.
- R2: A read (kind 0) or write (kind 1) without a conflict, to any region other than save RAM (region 2), costs 1 cycle.
- R3: An access to save RAM (region 2) costs 2 cycles, or 4 when it conflicts.
- R4: A conflicting access to program ROM (region 1) or other (region 0) costs 2 cycles. A conflicting access to internal work RAM (region 3) costs 3 cycles.
- R5: An idle cycle (kind 2) is charged exactly like a read to the same regions.
- R6: A jump/return end (kind 3) costs the memory part plus 1 when the coprocessor region is program ROM, plus 1 more if that access also conflicts. Outside program ROM it costs only the memory part.
- R7: A taken branch (kind 4) costs the memory part plus 1 only when the region is program ROM and `target_lsb` is 1. `target_lsb` has no effect for any other kind or region.
- R8: A request is accepted on a clock edge when `req_valid` is high and nothing is pending. `ready` is then visible after the N-th edge, counting the accepting edge as the first, where N is the cost, and it is high for exactly one cycle.
- R9: `stall_count` shows the accepted cost from the cycle after acceptance and stays stable while the request is pending, even if the request fields change.
- R10: `cycle_total` grows by the completed request's cost on the edge that ends it, and is otherwise unchanged.
- R11: After reset, `ready` is 0, `stall_count` is 0 and `cycle_total` is 0.
- R12: Unused kind codes 5 to 7 are charged like an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request, held until `ready` |
| cop_region | input | 3 | Region hit by the coprocessor (0 other, 1 program ROM, 2 save RAM, 3 work RAM, 4 registers) |
| host_region | input | 3 | Region hit by the main processor in the same cycle, same coding |
| access_kind | input | 3 | 0 read, 1 write, 2 idle, 3 jump/return end, 4 taken branch |
| target_lsb | input | 1 | Lowest bit of the branch target address |
| ready | output | 1 | One-cycle pulse when the access cost has elapsed |
| stall_count | output | COST_W | Cost of the accepted request, in cycles |
| cycle_total | output | TOTAL_W | Running sum of charged cycles |

## Verification
The assertions assume that the requester keeps `req_valid` high until it sees `ready`, and that the region and kind fields carry known values when a request is accepted. They also rely on every computed cost being at least one cycle. The bench raises a request on a falling edge and changes the request fields only after the accepting edge, to show that the latched cost is kept. It drops `req_valid` on the falling edge after `ready` is seen, so no request is ever accepted twice.

// File: rtl/ws_pkg.sv
package ws_pkg;

  localparam int unsigned REGION_W = 3;
  localparam int unsigned KIND_W   = 3;
  localparam int unsigned COST_MAX = 4;

  typedef enum logic [REGION_W-1:0] {
    RG_OTHER    = 3'd0,
    RG_PROG_ROM = 3'd1,
    RG_SAVE_RAM = 3'd2,
    RG_WORK_RAM = 3'd3,
    RG_REGS     = 3'd4
  } region_e;

  typedef enum logic [KIND_W-1:0] {
    AK_READ     = 3'd0,
    AK_WRITE    = 3'd1,
    AK_IDLE     = 3'd2,
    AK_JUMP_END = 3'd3,
    AK_BRANCH   = 3'd4
  } kind_e;

  // memory part of an access: depends on region and on a collision
  function automatic int unsigned bus_cost(input logic [REGION_W-1:0] region,
                                           input logic clash);
    case (region)
      RG_SAVE_RAM: return clash ? 4 : 2;
      RG_WORK_RAM: return clash ? 3 : 1;
      default:     return clash ? 2 : 1;
    endcase
  endfunction

  // penalty when a jump or return ends while running from program ROM
  function automatic int unsigned jump_cost(input logic rom, input logic clash);
    if (!rom) return 0;
    return clash ? 2 : 1;
  endfunction

  // penalty for a taken branch to an odd target in program ROM
  function automatic int unsigned branch_cost(input logic rom, input logic odd);
    return (rom && odd) ? 1 : 0;
  endfunction

endpackage

// File: rtl/ws_region_match.sv
module ws_region_match
  import ws_pkg::*;
#(
  parameter int unsigned RW = REGION_W
) (
  input  logic [RW-1:0] cop_region,
  input  logic [RW-1:0] host_region,
  output logic          conflict,
  output logic          cop_in_rom
);

  // R1: equal regions collide unless both sit in the register space
  always_comb begin
    conflict   = (cop_region == host_region) && (cop_region != RW'(RG_REGS));
    cop_in_rom = (cop_region == RW'(RG_PROG_ROM));
  end

endmodule

// File: rtl/ws_cost_calc.sv
module ws_cost_calc
  import ws_pkg::*;
#(
  parameter int unsigned RW     = REGION_W,
  parameter int unsigned KW     = KIND_W,
  parameter int unsigned COST_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic [RW-1:0]     region,
  input  logic              conflict,
  input  logic              rom,
  input  logic [KW-1:0]     kind,
  input  logic              odd,
  output logic [COST_W-1:0] cost
);

  logic [COST_W-1:0] mem_part;
  logic [COST_W-1:0] flow_part;

  always_comb begin
    mem_part = COST_W'(bus_cost(region, conflict));
    case (kind)
      KW'(AK_JUMP_END): flow_part = COST_W'(jump_cost(rom, conflict));
      KW'(AK_BRANCH):   flow_part = COST_W'(branch_cost(rom, odd));
      default:          flow_part = '0;  // R5, R12: read, write, idle, unused
    endcase
    cost = mem_part + flow_part;
  end

  // R5 / R12: kinds other than jump end and branch carry no flow penalty
  assert_plain_kind_no_flow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && kind != KW'(AK_JUMP_END) && kind != KW'(AK_BRANCH)) |-> (flow_part == '0))
    else $error("plain kind carried a flow penalty");

  // R7: an even branch target never pays the branch penalty
  assert_even_branch_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && kind == KW'(AK_BRANCH) && !odd) |-> (flow_part == '0))
    else $error("even branch target was charged");

  // R8: every cost is at least one cycle and at most the largest case
  assert_cost_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sample |-> (cost != '0 && cost <= COST_W'(COST_MAX)))
    else $error("cost out of range");

endmodule

// File: rtl/ws_stall_timer.sv
module ws_stall_timer #(
  parameter int unsigned COST_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [COST_W-1:0] cost_in,
  output logic              accept,
  output logic              ready,
  output logic [COST_W-1:0] stall_count
);

  logic              busy_q;
  logic [COST_W-1:0] remain_q;
  logic [COST_W-1:0] held_q;

  assign accept      = req && !busy_q;
  assign ready       = busy_q && (remain_q == COST_W'(1));
  assign stall_count = held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      remain_q <= '0;
      held_q   <= '0;
    end else if (accept) begin
      busy_q   <= 1'b1;
      remain_q <= cost_in;
      held_q   <= cost_in;
    end else if (busy_q) begin
      if (ready) busy_q <= 1'b0;
      else       remain_q <= remain_q - COST_W'(1);
    end
  end

  // R8: ready is a single-cycle pulse
  assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready)
    else $error("ready held for more than one cycle");

  // R8: a request is never accepted with a zero cost
  assert_nonzero_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (cost_in != '0))
    else $error("zero cost accepted");

  // R8: remaining count stays within the accepted cost
  assert_remain_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (remain_q != '0 && remain_q <= held_q))
    else $error("remaining count out of bounds");

  // R9: the reported cost holds while a request is pending
  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(stall_count))
    else $error("stall_count moved while pending");

endmodule

// File: rtl/ws_cycle_accum.sv
module ws_cycle_accum #(
  parameter int unsigned COST_W  = 3,
  parameter int unsigned TOTAL_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               add_en,
  input  logic [COST_W-1:0]  add_val,
  output logic [TOTAL_W-1:0] total
);

  logic [TOTAL_W-1:0] total_q;

  assign total = total_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      total_q <= '0;
    else if (add_en) total_q <= total_q + TOTAL_W'(add_val);
  end

  // R10: one step per completed request, by its cost
  assert_total_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    add_en |=> (total == $past(total) + TOTAL_W'($past(add_val))))
    else $error("total did not grow by the cost");

  // R10: no change without a completion
  assert_total_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !add_en |=> $stable(total))
    else $error("total moved without a completion");

endmodule

// File: rtl/ws_wait_state_gen.sv
module ws_wait_state_gen
  import ws_pkg::*;
#(
  parameter int unsigned COST_W  = 3,
  parameter int unsigned TOTAL_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [2:0]          cop_region,
  input  logic [2:0]          host_region,
  input  logic [2:0]          access_kind,
  input  logic                target_lsb,
  output logic                ready,
  output logic [COST_W-1:0]   stall_count,
  output logic [TOTAL_W-1:0]  cycle_total
);

  localparam int unsigned RW = REGION_W;
  localparam int unsigned KW = KIND_W;

  logic              conflict;
  logic              cop_in_rom;
  logic              accept;
  logic [COST_W-1:0] cost_now;

  ws_region_match #(.RW(RW)) u_match (
    .cop_region  (cop_region),
    .host_region (host_region),
    .conflict    (conflict),
    .cop_in_rom  (cop_in_rom)
  );

  ws_cost_calc #(.RW(RW), .KW(KW), .COST_W(COST_W)) u_cost (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample   (accept),
    .region   (cop_region),
    .conflict (conflict),
    .rom      (cop_in_rom),
    .kind     (access_kind),
    .odd      (target_lsb),
    .cost     (cost_now)
  );

  ws_stall_timer #(.COST_W(COST_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req_valid),
    .cost_in     (cost_now),
    .accept      (accept),
    .ready       (ready),
    .stall_count (stall_count)
  );

  ws_cycle_accum #(.COST_W(COST_W), .TOTAL_W(TOTAL_W)) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .add_en  (ready),
    .add_val (stall_count),
    .total   (cycle_total)
  );

  // R1: both sides in the register space never collide
  assert_regs_no_clash_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cop_region == RW'(RG_REGS) && host_region == RW'(RG_REGS) &&
     access_kind == KW'(AK_READ)) |-> (cost_now == COST_W'(1)))
    else $error("register space treated as conflict");

  // R3: save RAM data accesses cost two or four cycles
  assert_save_ram_cost_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cop_region == RW'(RG_SAVE_RAM) && access_kind <= KW'(AK_IDLE)) |->
    (cost_now == COST_W'(2) || cost_now == COST_W'(4)))
    else $error("save RAM cost wrong");

  // R4: a work RAM collision on a data access costs three cycles
  assert_work_ram_clash_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cop_region == RW'(RG_WORK_RAM) && host_region == RW'(RG_WORK_RAM) &&
     access_kind <= KW'(AK_WRITE)) |-> (cost_now == COST_W'(3)))
    else $error("work RAM collision cost wrong");

endmodule

// File: tb/sim_ws_wait_state_gen.sv
`timescale 1ns/1ps
module sim_ws_wait_state_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [2:0]  cop = 3'd0;
  logic [2:0]  host = 3'd0;
  logic [2:0]  kind = 3'd0;
  logic        lsb = 1'b0;
  logic        ready;
  logic [2:0]  stall_count;
  logic [63:0] cycle_total;

  int checks = 0;
  int failures = 0;
  longint unsigned exp_total = 0;

  typedef struct {
    int              cost;
    longint unsigned total;
    string           tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  ws_wait_state_gen u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req), .cop_region(cop),
    .host_region(host), .access_kind(kind), .target_lsb(lsb),
    .ready(ready), .stall_count(stall_count), .cycle_total(cycle_total)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // expected cost restated from the requirements
  function automatic int model_cost(input int c, input int h, input int k, input int b);
    bit clash = (c == h) && (c != 4);
    int n;
    if (c == 2)      n = clash ? 4 : 2;
    else if (c == 3) n = clash ? 3 : 1;
    else             n = clash ? 2 : 1;
    if (k == 3 && c == 1) n = n + (clash ? 2 : 1);
    if (k == 4 && c == 1 && b == 1) n = n + 1;
    return n;
  endfunction

  task automatic issue(input int c, input int h, input int k, input int b,
                       input string tag);
    int exp;
    int lat;
    bit steady;
    item_t it;
    exp = model_cost(c, h, k, b);
    exp_total += longint'(exp);
    it.cost = exp; it.total = exp_total; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    cop = 3'(c); host = 3'(h); kind = 3'(k); lsb = b[0]; req = 1'b1;
    lat = 0;
    steady = 1'b1;
    do begin
      @(posedge clk); #1;
      lat++;
      if (lat == 1) begin
        // R9: scramble the fields after acceptance
        cop = 3'(c + 1); host = 3'(h + 2); kind = 3'(k + 1); lsb = ~b[0];
      end
      if (stall_count != 3'(exp)) steady = 1'b0;
    end while (!ready && lat < 10);
    check(lat == exp, tag, "R8 ready latency", lat, exp);
    check(steady, "R9", "stall_count held", stall_count, exp);
    @(negedge clk);
    req = 1'b0;
    @(posedge clk); #1;
    check(ready == 1'b0, "R8", "ready pulse ends", ready, 0);
  endtask

  // monitor: pops the scoreboard as results appear
  initial begin
    forever begin
      @(posedge clk); #1;
      if (rst_n && ready) begin
        item_t it;
        if (sb.size() == 0) begin
          check(1'b0, "R8", "unexpected ready", 1, 0);
        end else begin
          it = sb.pop_front();
          check(stall_count == 3'(it.cost), it.tag, "cost", stall_count, it.cost);
          @(posedge clk); #1;
          check(cycle_total == it.total, "R10", "cycle_total", cycle_total, it.total);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(ready == 1'b0, "R11", "reset ready", ready, 0);
    check(stall_count == 3'd0, "R11", "reset stall_count", stall_count, 0);
    check(cycle_total == 64'd0, "R11", "reset total", cycle_total, 0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    check(cycle_total == 64'd0, "R11", "total after release", cycle_total, 0);

    issue(4, 4, 0, 0, "R1");   // register space both sides: 1
    issue(0, 1, 0, 0, "R2");   // other, no clash: 1
    issue(3, 2, 1, 0, "R2");   // work RAM write, no clash: 1
    issue(2, 0, 0, 0, "R3");   // save RAM: 2
    issue(2, 2, 1, 0, "R3");   // save RAM clash: 4
    issue(1, 1, 1, 0, "R4");   // program ROM clash: 2
    issue(0, 0, 0, 0, "R4");   // other clash: 2
    issue(3, 3, 0, 0, "R4");   // work RAM clash: 3
    issue(3, 3, 2, 0, "R5");   // idle work RAM clash: 3
    issue(2, 2, 2, 0, "R5");   // idle save RAM clash: 4
    issue(1, 0, 3, 0, "R6");   // jump end ROM: 2
    issue(1, 1, 3, 0, "R6");   // jump end ROM clash: 4
    issue(3, 3, 3, 0, "R6");   // jump end work RAM clash: 3
    issue(1, 0, 4, 1, "R7");   // odd branch ROM: 2
    issue(1, 0, 4, 0, "R7");   // even branch ROM: 1
    issue(3, 0, 4, 1, "R7");   // odd branch work RAM: 1
    issue(1, 0, 0, 1, "R7");   // lsb on a read: 1
    issue(3, 3, 6, 1, "R12");  // unused kind, work RAM clash: 3
    issue(1, 0, 7, 1, "R12");  // unused kind in ROM: 1

    repeat (4) @(posedge clk);
    #1;
    check(sb.size() == 0, "R8", "scoreboard drained", sb.size(), 0);
    check(cycle_total == exp_total, "R10", "final total", cycle_total, exp_total);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule